// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block keeps the sticky exception flags of a floating-point status register and decides, for each completed floating-point operation, whether an arithmetic trap is raised. Every operation that completes presents a raw exception vector with six bits: invalid, divide-by-zero, overflow, underflow, inexact and integer overflow. It also presents an ignore mask, a destination register number and a qualifier that says whether software completion was requested.

There are two trap paths. An operation without software completion records every raised exception in the sticky flags, drops the ignored bits, and traps on whatever is left, whatever the enables say. An operation with software completion drops the ignored bits first, records only the rest, and then filters them through a separate trap-enable register. A trap from this path carries a completion marker in its summary word. A trap is reported as a one-cycle strobe, together with a summary word and a one-hot mask of the destination register. The summary and the mask stay stable until the next operation. A simple write port loads the flag register and the enable register.

Top module: `fpx_trap_unit`

## Requirements
- R1: Flag bit positions are invalid=0, divzero=1, overflow=2, underflow=3, inexact=4, int-overflow=5. After reset, `flags_o`, `trap_o`, `summary_o` and `regmask_o` are all zero.
- R2: Without software completion (`op_swc_i`=0), all raw bits of a valid operation are OR-ed into `flags_o` in the next cycle, ignored bits included.
- R3: Without software completion, `trap_o` pulses one cycle after the operation when `raw & ~ignore` is nonzero, regardless of `trap_en_o`.
- R4: With software completion (`op_swc_i`=1), only `raw & ~ignore` is OR-ed into `flags_o`.
- R5: With software completion, `trap_o` pulses only when `raw & ~ignore & trap_en_o` is nonzero.
- R6: Summary bits 0..5 are invalid, divzero, overflow, underflow, inexact and int-overflow, taken from the trapping bits (the unignored bits, further masked by the enables in the completion path). Bit 6 is set only for a completion-path trap.
- R7: On a trap, `regmask_o` is 64-bit one-hot with bit `op_reg_i` set. Summary and mask hold until the next valid operation.
- R8: `trap_o` is high for exactly one cycle per trapping operation and is low one cycle after any cycle without a valid operation.
- R9: Flags are sticky. They are cleared only by reset or by a flag write (`wr_flags_i`), and that write wins over an update in the same cycle.
- R10: `wr_en_i` loads `trap_en_o` in the next cycle. An operation in the same cycle uses the previous enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation completed this cycle |
| op_raw_i | input | 6 | Raw exception bits |
| op_ign_i | input | 6 | Ignore mask |
| op_swc_i | input | 1 | Software-completion qualifier |
| op_reg_i | input | 6 | Destination register number |
| wr_flags_i | input | 1 | Load the flag register |
| wr_en_i | input | 1 | Load the trap-enable register |
| wr_data_i | input | 6 | Write data for either register |
| flags_o | output | 6 | Sticky exception flags |
| trap_en_o | output | 6 | Trap-enable register |
| trap_o | output | 1 | Trap strobe |
| summary_o | output | 7 | Trap summary word |
| regmask_o | output | 64 | One-hot destination register mask |

## Verification
The bench sweeps every raw vector against a set of ignore masks in both paths. Applying the same pattern with and without completion shows whether ignored bits reach the flags and whether the enables gate the trap. The enable register is swept with a fixed raw vector, which separates an enable-gated trap from an ignore-gated one. Walking the register number across all 64 values checks the one-hot mask. Collisions between a write and an update, and between back-to-back operations, exercise the write priority and the one-cycle strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int unsigned NEXC  = 6;
    localparam int unsigned SUMW  = NEXC + 1;
    localparam int unsigned REGW  = 6;
    localparam int unsigned NREG  = 1 << REGW;
    localparam int unsigned SWC_BIT = NEXC;

    typedef logic [NEXC-1:0] exc_t;

    typedef struct packed {
        exc_t              flags;
        exc_t              en;
        logic              trap;
        logic [SUMW-1:0]   summary;
        logic [NREG-1:0]   regmask;
    } state_t;
endpackage

// File: rtl/fpx_path_sel.sv
module fpx_path_sel
    import fpx_pkg::*;
(
    input  exc_t raw_i,
    input  exc_t ign_i,
    input  exc_t en_i,
    input  logic swc_i,
    output exc_t sticky_o,
    output exc_t trapbits_o
);
    exc_t kept;
    always_comb begin
        kept = raw_i & ~ign_i;
        if (swc_i) begin
            sticky_o   = kept;
            trapbits_o = kept & en_i;
        end else begin
            sticky_o   = raw_i;
            trapbits_o = kept;
        end
    end
endmodule

// File: rtl/fpx_decode.sv
module fpx_decode
    import fpx_pkg::*;
(
    input  logic [REGW-1:0] reg_i,
    output logic [NREG-1:0] onehot_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign onehot_o[i] = (reg_i == REGW'(i));
    end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid_i,
    input  logic [5:0]      op_raw_i,
    input  logic [5:0]      op_ign_i,
    input  logic            op_swc_i,
    input  logic [5:0]      op_reg_i,
    input  logic            wr_flags_i,
    input  logic            wr_en_i,
    input  logic [5:0]      wr_data_i,
    output logic [5:0]      flags_o,
    output logic [5:0]      trap_en_o,
    output logic            trap_o,
    output logic [6:0]      summary_o,
    output logic [63:0]     regmask_o
);
    state_t st_q, st_d;
    exc_t sticky, trapbits;
    logic [NREG-1:0] onehot;

    fpx_path_sel u_sel (
        .raw_i(op_raw_i), .ign_i(op_ign_i), .en_i(st_q.en), .swc_i(op_swc_i),
        .sticky_o(sticky), .trapbits_o(trapbits)
    );

    fpx_decode u_dec (.reg_i(op_reg_i), .onehot_o(onehot));

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (op_valid_i) begin
            st_d.flags = st_q.flags | sticky;
            st_d.trap  = |trapbits;
            if (|trapbits) begin
                st_d.summary = {op_swc_i, trapbits};
                st_d.regmask = onehot;
            end else begin
                st_d.summary = '0;
                st_d.regmask = '0;
            end
        end
        if (wr_flags_i) st_d.flags = wr_data_i;
        if (wr_en_i)    st_d.en    = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o   = st_q.flags;
    assign trap_en_o = st_q.en;
    assign trap_o    = st_q.trap;
    assign summary_o = st_q.summary;
    assign regmask_o = st_q.regmask;
endmodule

module fpx_trap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid_i,
    input logic [5:0]  op_raw_i,
    input logic [5:0]  op_ign_i,
    input logic        op_swc_i,
    input logic        wr_flags_i,
    input logic [5:0]  wr_data_i,
    input logic [5:0]  flags_o,
    input logic        trap_o,
    input logic [6:0]  summary_o,
    input logic [63:0] regmask_o
);
    // R8
    trap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !trap_o);
    // R7
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $countones(regmask_o) == 1);
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flags_i |=> (flags_o & $past(flags_o)) == $past(flags_o));
    // R9
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags_i |=> flags_o == $past(wr_data_i));
    // R3
    plain_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !op_swc_i && |(op_raw_i & ~op_ign_i)) |=> trap_o);
    // R6
    swc_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !op_swc_i) |=> !summary_o[6]);
endmodule

bind fpx_trap_unit fpx_trap_unit_chk u_chk (.*);

// File: tb/fpx_trap_unit_bench.sv
module fpx_trap_unit_bench;
    logic clk = 0, rst_n = 0;
    logic op_valid_i = 0, op_swc_i = 0, wr_flags_i = 0, wr_en_i = 0;
    logic [5:0] op_raw_i = 0, op_ign_i = 0, op_reg_i = 0, wr_data_i = 0;
    logic [5:0] flags_o, trap_en_o;
    logic trap_o;
    logic [6:0] summary_o;
    logic [63:0] regmask_o;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    fpx_trap_unit u_fpx_trap_unit (.*);

    task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic set_en(logic [5:0] v);
        @(negedge clk); wr_en_i = 1; wr_data_i = v;
        @(negedge clk); wr_en_i = 0;
    endtask
    task automatic clr_flags();
        @(negedge clk); wr_flags_i = 1; wr_data_i = 0;
        @(negedge clk); wr_flags_i = 0;
    endtask
    task automatic do_op(logic [5:0] raw, logic [5:0] ign, logic swc, logic [5:0] rg);
        @(negedge clk);
        op_valid_i = 1; op_raw_i = raw; op_ign_i = ign; op_swc_i = swc; op_reg_i = rg;
        @(negedge clk);
        op_valid_i = 0;
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] ex, tb, fl;
        logic [5:0] igns [4];
        igns[0] = 6'h00; igns[1] = 6'h3f; igns[2] = 6'h15; igns[3] = 6'h2a;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", flags_o, 0); chk("R1 trap", trap_o, 0);
        chk("R1 summary", summary_o, 0); chk("R1 mask", regmask_o, 0);
        rst_n = 1;
        // R2 R3 R4 R5 R6 sweep
        for (int swc = 0; swc < 2; swc++) begin
            for (int e = 0; e < 4; e++) begin
                set_en(e == 0 ? 6'h3f : (e == 1 ? 6'h00 : (e == 2 ? 6'h0f : 6'h30)));
                for (int k = 0; k < 4; k++) begin
                    for (int r = 0; r < 64; r++) begin
                        clr_flags();
                        do_op(6'(r), igns[k], swc[0], 6'(r));
                        ex = swc ? (6'(r) & ~igns[k]) : 6'(r);
                        tb = swc ? (6'(r) & ~igns[k] & trap_en_o) : (6'(r) & ~igns[k]);
                        chk(swc ? "R4 flags" : "R2 flags", flags_o, ex);
                        chk(swc ? "R5 trap" : "R3 trap", trap_o, |tb);
                        if (|tb) begin
                            chk("R6 summary", summary_o, {swc[0], tb});
                            chk("R7 mask", regmask_o, 64'd1 << r);
                        end
                        @(negedge clk);
                        chk("R8 pulse", trap_o, 0);
                    end
                end
            end
        end
        // R7 register walk and hold
        set_en(6'h3f);
        for (int g = 0; g < 64; g++) begin
            do_op(6'h01, 0, 0, 6'(g));
            chk("R7 mask", regmask_o, 64'd1 << g);
            repeat (2) @(negedge clk);
            chk("R7 hold", regmask_o, 64'd1 << g);
        end
        // R8 back-to-back
        @(negedge clk);
        op_valid_i = 1; op_raw_i = 6'h02; op_ign_i = 0; op_swc_i = 0; op_reg_i = 3;
        @(negedge clk);
        chk("R8 first", trap_o, 1);
        op_raw_i = 6'h04; op_reg_i = 5;
        @(negedge clk);
        op_valid_i = 0;
        chk("R8 second", trap_o, 1); chk("R8 second sum", summary_o, 7'h04);
        @(negedge clk);
        chk("R8 drop", trap_o, 0);
        // R9 sticky and write priority
        clr_flags();
        do_op(6'h01, 0, 0, 0);
        do_op(6'h10, 0, 0, 0);
        chk("R9 sticky", flags_o, 6'h11);
        @(negedge clk);
        op_valid_i = 1; op_raw_i = 6'h3f; wr_flags_i = 1; wr_data_i = 6'h02;
        @(negedge clk);
        op_valid_i = 0; wr_flags_i = 0;
        chk("R9 write wins", flags_o, 6'h02);
        // R10 enable write timing
        set_en(6'h00);
        @(negedge clk);
        op_valid_i = 1; op_raw_i = 6'h08; op_ign_i = 0; op_swc_i = 1;
        wr_en_i = 1; wr_data_i = 6'h08;
        @(negedge clk);
        op_valid_i = 0; wr_en_i = 0;
        chk("R10 old enable", trap_o, 0);
        chk("R10 loaded", trap_en_o, 6'h08);
        do_op(6'h08, 0, 1, 9);
        chk("R10 new enable", trap_o, 1);
        fl = flags_o;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule